// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Code Select

This block sequences five shared pins through power-up. Each pin carries a strap level while power settles and becomes a clock output once the level has been taken. When the power-good input rises, every pin stays three-stated for a timed window counted in reference clock cycles. On the last edge of that window the five pin levels are captured: four become the frequency-select strap and one becomes the mode strap. The pins are turned into outputs one cycle later. This delay means the sampling point never sees a pin that the block itself drives.

The captured levels stay fixed until power-good falls and rises again. No other event re-arms the capture. A second path picks the 5-bit frequency code that the synthesizers use. A source bit in the software configuration byte chooses either the hardware code, which is a constant 1 above the four strap bits, or a code assembled from five other bits of that byte.

Top module: `strap_power_seq`

## Requirements
- R1: After power-good goes high, the straps are captured on rising edge number WINDOW_CYC. Before that edge, strap_fs and strap_mode read 0.
- R2: pin_oe is all zero while power-good is low, and it stays zero up to and including the capture edge.
- R3: All five pin_oe bits rise together on the edge right after the capture edge, and they then stay high while power-good is high.
- R4: Once captured, strap_fs and strap_mode do not change while power-good stays high, however pin_in changes.
- R5: When power-good falls, the straps and pin_oe clear to 0. When it rises again, the full window restarts, including the case where the fall came part way through a window.
- R6: The pin_in bits map as follows: bit 0 is FS0, bit 1 is FS1, bit 2 is FS2, bit 3 is FS3 and bit 4 is the mode strap. strap_fs is {FS3,FS2,FS1,FS0}. strap_mode = 1 selects the reference clock output for the shared stop/reference pin, and 0 selects the stop input.
- R7: When cfg_byte0 bit 3 is 0, freq_code = {1, FS3, FS2, FS1, FS0}.
- R8: When cfg_byte0 bit 3 is 1, freq_code = {bit2, bit1, bit6, bit5, bit4} of cfg_byte0.
- R9: cfg_byte0 bits 0 and 7 never affect freq_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply good. Low acts as power-off and clears all state |
| pin_in | input | 5 | Sampled levels of the shared pins |
| cfg_byte0 | input | 8 | Software configuration byte with the source select and software code |
| pin_oe | output | 5 | Output enable for each shared pin |
| strap_fs | output | 4 | Captured frequency-select strap |
| strap_mode | output | 1 | Captured mode strap |
| freq_code | output | 5 | Selected frequency code |

## Verification
The assertions assume that pwr_good is synchronous to clk and is only treated as a clear while it is low. They also assume that pin_in is settled at the capture edge. The bench therefore changes pwr_good, pin_in and cfg_byte0 only on falling clock edges. It sweeps all 32 strap patterns, and for each pattern it sweeps all 256 configuration bytes. It also drops power-good part way through a window to check the restart.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
    localparam int PIN_COUNT = 5;
    localparam int FS_W      = 4;
    localparam int CODE_W    = 5;
    localparam int IDX_MODE  = 4;
    localparam int SRC_BIT   = 3;

    typedef struct packed {
        logic [PIN_COUNT-1:0] held;
        logic                 valid;
        logic                 oe;
    } capture_st_t;

    function automatic logic [CODE_W-1:0] soft_code(input logic [7:0] b);
        return {b[2], b[1], b[6], b[5], b[4]};
    endfunction
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WINDOW_CYC = 28636
) (
    input  logic clk,
    input  logic pwr_good,
    output logic fire,
    output logic done
);
    localparam int CNT_W = $clog2(WINDOW_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_st_t;

    tmr_st_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        fire  = !tmr_q.done && (tmr_q.cnt == LAST);
        if (!tmr_q.done) begin
            if (fire) tmr_d.done = 1'b1;
            else      tmr_d.cnt  = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!pwr_good) tmr_q <= '0;
        else           tmr_q <= tmr_d;
    end

    assign done = tmr_q.done;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!pwr_good)
        !tmr_q.done |-> tmr_q.cnt <= LAST); // R1
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!pwr_good)
        fire |=> (done && !fire)); // R1
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 pwr_good,
    input  logic                 fire,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] held,
    output logic                 valid,
    output logic                 oe
);
    capture_st_t cap_q, cap_d;

    always_comb begin
        cap_d    = cap_q;
        cap_d.oe = cap_q.valid;
        if (fire && !cap_q.valid) begin
            cap_d.held  = pin_in;
            cap_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!pwr_good) cap_q <= '0;
        else           cap_q <= cap_d;
    end

    assign held  = cap_q.held;
    assign valid = cap_q.valid;
    assign oe    = cap_q.oe;

    AST_CAPTURE_ON_FIRE: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(valid) |-> $past(fire)); // R1
    AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!pwr_good)
        oe |-> valid); // R3
    AST_OE_LAGS_CAPTURE: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(oe) |-> $past(valid)); // R3
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!pwr_good)
        (valid && $past(valid)) |-> $stable(held)); // R4
endmodule

// File: rtl/freq_code_select.sv
module freq_code_select
    import strap_seq_pkg::*;
(
    input  logic [FS_W-1:0]   hw_fs,
    input  logic [7:0]        cfg_byte0,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        if (cfg_byte0[SRC_BIT]) code = soft_code(cfg_byte0);
        else                    code = {1'b1, hw_fs};
    end
endmodule

// File: rtl/strap_power_seq.sv
module strap_power_seq
    import strap_seq_pkg::*;
#(
    parameter int WINDOW_CYC = 28636
) (
    input  logic                 clk,
    input  logic                 pwr_good,
    input  logic [PIN_COUNT-1:0] pin_in,
    input  logic [7:0]           cfg_byte0,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [FS_W-1:0]      strap_fs,
    output logic                 strap_mode,
    output logic [CODE_W-1:0]    freq_code
);
    logic                 win_fire, win_done;
    logic [PIN_COUNT-1:0] held;
    logic                 held_valid, drive_en;

    strap_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
        .clk(clk), .pwr_good(pwr_good), .fire(win_fire), .done(win_done)
    );

    strap_capture u_cap (
        .clk(clk), .pwr_good(pwr_good), .fire(win_fire), .pin_in(pin_in),
        .held(held), .valid(held_valid), .oe(drive_en)
    );

    freq_code_select u_sel (
        .hw_fs(strap_fs), .cfg_byte0(cfg_byte0), .code(freq_code)
    );

    assign strap_fs   = held[FS_W-1:0];
    assign strap_mode = held[IDX_MODE];

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_oe
        assign pin_oe[i] = drive_en;
    end

    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!pwr_good)
        !win_done |-> pin_oe == '0); // R2
    AST_OE_ALL_SAME: assert property (@(posedge clk) disable iff (!pwr_good)
        (pin_oe == '0) || (pin_oe == '1)); // R3
endmodule

// File: tb/strap_power_seq_test.sv
module strap_power_seq_test;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] pin_in = '0;
    logic [7:0] cfg_byte0 = '0;
    logic [4:0] pin_oe;
    logic [3:0] strap_fs;
    logic       strap_mode;
    logic [4:0] freq_code;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    strap_power_seq #(.WINDOW_CYC(W)) uut (
        .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .cfg_byte0(cfg_byte0),
        .pin_oe(pin_oe), .strap_fs(strap_fs), .strap_mode(strap_mode),
        .freq_code(freq_code)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [4:0] exp_code(input logic [3:0] fs, input logic [7:0] b);
        if (b[3]) return {b[2], b[1], b[6], b[5], b[4]};
        return {1'b1, fs};
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc();
        // reset state
        chk("R2 oe off", pin_oe, 0);
        chk("R5 straps clear", {strap_mode, strap_fs}, 0);

        // R5: abort part way through a window
        pwr_good = 1'b1;
        pin_in = 5'h15;
        for (int k = 0; k < W - 3; k++) cyc();
        pwr_good = 1'b0;
        cyc();
        chk("R5 cleared after drop", {pin_oe, strap_mode, strap_fs}, 0);
        pwr_good = 1'b1;
        for (int k = 1; k < W; k++) begin
            cyc();
            chk("R5 R1 window restarts", {strap_mode, strap_fs}, 0);
        end

        for (int p = 0; p < 32; p++) begin
            pwr_good = 1'b0;
            pin_in = ~p[4:0];
            cyc();
            cyc();
            chk("R5 oe off in power-down", pin_oe, 0);
            pwr_good = 1'b1;
            for (int k = 1; k < W; k++) begin
                cyc();
                chk("R1 no early capture", {strap_mode, strap_fs}, 0);
                chk("R2 oe off in window", pin_oe, 0);
            end
            pin_in = p[4:0];
            cyc(); // capture edge
            chk("R6 fs strap", strap_fs, p & 15);
            chk("R6 mode strap", strap_mode, (p >> 4) & 1);
            chk("R2 oe off on capture edge", pin_oe, 0);
            cyc();
            chk("R3 oe all on", pin_oe, 31);
            pin_in = ~p[4:0];
            for (int k = 0; k < 3; k++) begin
                cyc();
                chk("R4 straps held", {strap_mode, strap_fs}, p);
                chk("R3 oe stays on", pin_oe, 31);
            end
            for (int b = 0; b < 256; b++) begin
                cfg_byte0 = b[7:0];
                #1;
                if (b[3]) chk("R8 soft code", freq_code, exp_code(p[3:0], b[7:0]));
                else      chk("R7 hw code", freq_code, exp_code(p[3:0], b[7:0]));
                if (b[0] || b[7]) begin
                    cfg_byte0 = b[7:0] & 8'h7E;
                    #1;
                    chk("R9 bits 0 and 7 ignored", freq_code, exp_code(p[3:0], b[7:0]));
                end
            end
            @(negedge clk);
        end
        finish_run();
    end
endmodule